// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slower clock whose average frequency is not an integer fraction of the reference. It does this by alternating between two integer divisors. The first divisor is used for a programmed number of output periods, then the second divisor for its own programmed number of periods, and the pattern repeats. With a 24 MHz reference, divisors of 733 and 732 used for two and three periods give a 3662-cycle pattern of five periods, which is about 32.77 kHz on average.

Two configuration words set it up. The divide word holds both divisor fields, a two-bit output-form selector and a run enable. The repeat word holds both repeat-count fields. Every field stores its value minus one. The block produces a one-cycle tick at the end of every output period. It also produces a clock output, whose form the selector picks: an approximately square wave, a copy of the tick, or held low.

Top module: `fdiv_dual_modulus`

## Requirements
- R1: Field layout. In `div_cfg`, bits 11:0 hold the first divisor minus one (A), bits 23:12 hold the second divisor minus one (B), bits 29:28 hold the output form, and bit 31 is the run enable. In `rep_cfg`, bits 11:0 hold the first repeat count minus one (P) and bits 23:12 hold the second repeat count minus one (Q).
- R2: While `rst` is high or the run enable is clear, `tick` and `clk_out` are low. When run is next enabled, the pattern restarts from the first divisor at the start of a period.
- R3: After the run enable rises, the first `tick` is seen in the sample taken after the (A+1)-th rising edge at which run is high.
- R4: Each output period lasts exactly the current divisor in clock cycles (field value plus one). It ends with `tick` high for one cycle.
- R5: The block runs P+1 periods with the first divisor, then Q+1 periods with the second divisor, and then repeats. It always starts with the first divisor.
- R6: One full pattern spans (A+1)(P+1)+(B+1)(Q+1) cycles and contains P+Q+2 ticks. For A=0x2DC, B=0x2DB, P=1 and Q=2, this is 3662 cycles.
- R7: Output form 2'b01 gives a square wave. `clk_out` is high for (N>>1)+1 cycles of each period, where N is that period's divisor field, starting in the cycle after the previous tick, and it is low for the rest of the period.
- R8: Output form 2'b10 makes `clk_out` equal to `tick` in every cycle.
- R9: Output forms 2'b00 and 2'b11 hold `clk_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | 32 | Divisor fields, output form and run enable |
| rep_cfg | input | 24 | Repeat-count fields |
| tick | output | 1 | One-cycle pulse at the end of each output period |
| clk_out | output | 1 | Clock output in the selected form |

## Verification
Several properties are checked on every cycle. Both outputs stay quiet while run is off. A tick always coincides with a counter that has just restarted. The active divisor changes only on a tick, and the pulse form mirrors the tick exactly. Other behaviours can only be shown by the bench scenarios. These are the exact length of each period, the order and count of the two divisor phases, the first-tick latency after enabling, the high time of the square wave, and the total length of the 24 MHz to 32 kHz pattern. The bench checks them against period lengths that it predicts itself, for directed and randomly drawn field values.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int FW       = 12;
  localparam int N0_LSB   = 0;
  localparam int N1_LSB   = FW;
  localparam int FORM_LSB = 28;
  localparam int RUN_BIT  = 31;
  localparam int REP_W    = 2 * FW;

  typedef enum logic [1:0] {
    FORM_LOW   = 2'b00,
    FORM_SQ    = 2'b01,
    FORM_PULSE = 2'b10,
    FORM_LOW2  = 2'b11
  } out_form_e;
endpackage

// File: rtl/fdiv_cfg_decode.sv
module fdiv_cfg_decode
  import fdiv_pkg::*;
#(
  parameter int W = FW
) (
  input  logic [31:0]      div_cfg,
  input  logic [2*W-1:0]   rep_cfg,
  output logic [W-1:0]     n0,
  output logic [W-1:0]     n1,
  output logic [W-1:0]     m0,
  output logic [W-1:0]     m1,
  output out_form_e        form,
  output logic             run
);
  always_comb begin
    n0   = div_cfg[N0_LSB +: W];
    n1   = div_cfg[N1_LSB +: W];
    m0   = rep_cfg[0 +: W];
    m1   = rep_cfg[W +: W];
    form = out_form_e'(div_cfg[FORM_LSB +: 2]);
    run  = div_cfg[RUN_BIT];
  end
endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = run && (cnt_q >= lim);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2: the counter is parked at zero after any cycle without run
  p_parked_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (cnt_q == '0));
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] n0,
  input  logic [W-1:0] n1,
  input  logic [W-1:0] m0,
  input  logic [W-1:0] m1,
  output logic [W-1:0] nsel,
  output logic         phase
);
  logic         phase_q;
  logic [W-1:0] rep_q;
  logic [W-1:0] msel;

  assign phase = phase_q;
  assign nsel  = phase_q ? n1 : n0;
  assign msel  = phase_q ? m1 : m0;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= 1'b0;
      rep_q   <= '0;
    end else if (wrap) begin
      if (rep_q >= msel) begin
        rep_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        rep_q   <= rep_q + 1'b1;
      end
    end
  end

  // R5: the divisor selection only moves at the end of a period
  p_phase_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(run) && !$stable(phase_q)) |-> $past(wrap));
endmodule

// File: rtl/fdiv_out_shape.sv
module fdiv_out_shape
  import fdiv_pkg::*;
#(
  parameter int W = FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] nsel,
  input  out_form_e    form,
  output logic         tick,
  output logic         clk_out
);
  logic tick_q, clk_q, sq;

  assign sq = run && (cnt <= (nsel >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      tick_q <= wrap;
      case (form)
        FORM_SQ:    clk_q <= sq;
        FORM_PULSE: clk_q <= wrap;
        default:    clk_q <= 1'b0;
      endcase
    end
  end

  assign tick    = tick_q;
  assign clk_out = clk_q;

  // R9: quiet forms never raise the clock output
  p_quiet_form_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(form) == FORM_LOW || $past(form) == FORM_LOW2) |-> !clk_q);
endmodule

// File: rtl/fdiv_dual_modulus.sv
module fdiv_dual_modulus
  import fdiv_pkg::*;
#(
  parameter int W = FW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     div_cfg,
  input  logic [2*W-1:0]  rep_cfg,
  output logic            tick,
  output logic            clk_out
);
  logic [W-1:0] n0, n1, m0, m1, nsel, cnt;
  logic         run, wrap, phase;
  out_form_e    form;

  fdiv_cfg_decode #(.W(W)) u_dec (
    .div_cfg(div_cfg), .rep_cfg(rep_cfg),
    .n0(n0), .n1(n1), .m0(m0), .m1(m1), .form(form), .run(run)
  );

  fdiv_period_cnt #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .lim(nsel), .cnt(cnt), .wrap(wrap)
  );

  fdiv_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .run(run), .wrap(wrap),
    .n0(n0), .n1(n1), .m0(m0), .m1(m1), .nsel(nsel), .phase(phase)
  );

  fdiv_out_shape #(.W(W)) u_out (
    .clk(clk), .rst(rst), .run(run), .wrap(wrap), .cnt(cnt), .nsel(nsel),
    .form(form), .tick(tick), .clk_out(clk_out)
  );

  // R1: configuration words are driven with known values
  p_cfg_known_r1: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({div_cfg, rep_cfg}));

  // R2: both outputs low after a cycle without run
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (!tick && !clk_out));

  // R4: a tick marks a period counter that has just restarted
  p_tick_restart_r4: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt == '0));

  // R8: pulse form mirrors the tick
  p_pulse_mirror_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(form) == FORM_PULSE && $past(!rst)) |-> (clk_out == tick));
endmodule

// File: tb/fdiv_dual_modulus_tb.sv
`timescale 1ns/1ps
module fdiv_dual_modulus_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] div_cfg = '0;
  logic [23:0] rep_cfg = '0;
  logic        tick, clk_out;
  int          nchk = 0, nerr = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fdiv_dual_modulus u_dut (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .rep_cfg(rep_cfg),
    .tick(tick), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pat_len(int a, int b, int p, int q);
    return (a + 1) * (p + 1) + (b + 1) * (q + 1);
  endfunction

  task automatic set_cfg(int a, int b, int p, int q, int form, bit en);
    div_cfg = {en, 1'b0, form[1:0], 4'b0, b[11:0], a[11:0]};
    rep_cfg = {q[11:0], p[11:0]};
  endtask

  // enables the divider and follows nper periods, returns total cycles
  task automatic run_seq(int a, int b, int p, int q, int form, int nper, output int total);
    int ph = 0, r = 0;
    total = 0;
    @(negedge clk); set_cfg(a, b, p, q, form, 1'b0);
    @(negedge clk); set_cfg(a, b, p, q, form, 1'b1);
    for (int k = 0; k < nper; k++) begin
      int cyc = 0, hi = 0, bad = 0, nf, expd;
      nf   = ph ? b : a;
      expd = nf + 1;
      do begin
        @(negedge clk);
        cyc++;
        if (clk_out) hi++;
        if (form == 2 && clk_out != tick) bad++;
        if ((form == 0 || form == 3) && clk_out) bad++;
      end while (!tick && cyc < 6000);
      total += cyc;
      if (k == 0) chk(cyc == expd, "R3 first tick", cyc, expd);
      else        chk(cyc == expd, ph ? "R5 second-divisor period" : "R4 period", cyc, expd);
      if (form == 1) chk(hi == (nf >> 1) + 1, "R7 square high time", hi, (nf >> 1) + 1);
      else if (form == 2) chk(bad == 0, "R8 pulse mirror", bad, 0);
      else chk(bad == 0, "R9 quiet output", bad, 0);
      if (r >= (ph ? q : p)) begin r = 0; ph = 1 - ph; end
      else r++;
    end
  endtask

  initial begin
    int tot, a, b, p, q, f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(tick == 0 && clk_out == 0, "R2 reset state", {tick, clk_out}, 0);
    rst = 0;

    // directed: small divisors, both phases, every form
    run_seq(3, 5, 1, 2, 1, 10, tot);
    chk(tot == 2 * pat_len(3, 5, 1, 2), "R5 two patterns", tot, 2 * pat_len(3, 5, 1, 2));
    run_seq(0, 2, 0, 0, 2, 6, tot);
    run_seq(4, 1, 2, 1, 0, 7, tot);
    run_seq(2, 6, 0, 1, 3, 6, tot);

    // R2: disabling silences outputs, re-enable restarts with the first divisor
    @(negedge clk); set_cfg(5, 9, 0, 0, 2, 1'b1);
    repeat (8) @(negedge clk);
    set_cfg(5, 9, 0, 0, 2, 1'b0);
    begin
      int loud = 0;
      repeat (20) begin @(negedge clk); if (tick || clk_out) loud++; end
      chk(loud == 0, "R2 run disabled", loud, 0);
    end
    run_seq(5, 9, 0, 0, 1, 4, tot);

    // R6: 24 MHz to ~32.768 kHz pattern
    run_seq(12'h2dc, 12'h2db, 1, 2, 1, 5, tot);
    chk(tot == 3662, "R6 pattern length", tot, 3662);
    run_seq(12'h2dc, 12'h2db, 1, 2, 2, 10, tot);
    chk(tot == 2 * 3662, "R6 two patterns", tot, 2 * 3662);

    // constrained random fields
    for (int i = 0; i < 8; i++) begin
      a = $urandom_range(0, 20); b = $urandom_range(0, 20);
      p = $urandom_range(0, 3);  q = $urandom_range(0, 3);
      f = $urandom_range(0, 3);
      run_seq(a, b, p, q, f, 2 * (p + q + 2), tot);
      chk(tot == 2 * pat_len(a, b, p, q), "R6 random pattern", tot, 2 * pat_len(a, b, p, q));
    end

    // R1: a field change in the repeat word changes the phase lengths
    run_seq(1, 7, 3, 0, 1, 5, tot);
    chk(tot == pat_len(1, 7, 3, 0), "R1 repeat fields", tot, pat_len(1, 7, 3, 0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule